// File: doc/BRIEF.md
# Predicated Packed-SIMD Immediate Adder

This block adds a signed immediate to every narrow element packed inside a 64-bit source word. The element width is chosen at run time: bytes, halfwords or words. The number of elements touched is the vector length multiplied by the sub-vector length. Elements are gathered into sub-vector groups, and one predicate bit enables or disables a whole group.

A disabled group is handled in one of two ways. It keeps its old value, or, when zeroing is selected, it is forced to zero. The predicate can be complemented before use. The block is fed with the source word and the controls from an issue stage. One cycle later it returns the new destination word and a per-byte write-enable, which a register file can use to merge the result.

Top module: `pred_simd_addi`

## Requirements
- R1: While reset is asserted, and after it is released until the first valid input, `out_valid`, `dst` and `wen` are all zero.
- R2: A result appears exactly one clock after `in_valid` is sampled high, with `out_valid` high in that cycle. `out_valid` is low in the cycle after `in_valid` is sampled low.
- R3: `ew` selects the element size: code 0 is 8 bits, code 1 is 16 bits, code 2 is 32 bits, and code 3 behaves like code 0. Element k occupies bits k*W to k*W+W-1, so element 0 sits in the least significant bits.
- R4: The number of processed elements is `vl`*(`subvl`+1), where `subvl` code s means groups of s+1 elements. This count is clamped to the number of elements that fit in 64 bits. When `vl` is 0, no element is processed.
- R5: Predicate bit g governs group g, which holds elements g*S through g*S+S-1 for a group size S.
- R6: When `inv` is 1, every predicate bit is complemented before it is used.
- R7: An active element, meaning one in range whose effective predicate bit is 1, becomes its old value plus `imm`. `imm` is sign-extended and truncated to the element width, and the sum wraps modulo the element width with no carry into a neighbouring element.
- R8: With `zero` low, an in-range element whose effective predicate bit is 0 keeps its old value and its bytes are not enabled.
- R9: With `zero` high, an in-range element whose effective predicate bit is 0 is written as zero and its bytes are enabled.
- R10: Bytes outside the processed range always keep their source value and always have `wen` low. `wen` is high for every byte of an active element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and controls are valid |
| ew | input | 2 | Element width code |
| vl | input | 4 | Vector length, counted in groups |
| subvl | input | 2 | Group size minus one |
| pred | input | 8 | Predicate word, one bit per group |
| inv | input | 1 | Complement the predicate |
| zero | input | 1 | Zero the masked in-range elements |
| imm | input | 12 | Signed immediate |
| src | input | 64 | Source word |
| out_valid | output | 1 | Result is valid |
| dst | output | 64 | Destination word |
| wen | output | 8 | Per-byte write-enable |

## Verification
The hardest situation to reach is a range that ends part-way through a group at the clamp boundary. This happens when `vl`*(`subvl`+1) exceeds the number of elements that fit in the word: for example, groups of three bytes with `vl` of 3 or more, or halfword groups of size three. In that case a predicate bit governs only part of its group, and the predicate bits beyond the clamp must have no effect. The stimulus sweeps every width code, every group size and `vl` from 0 to 5 against a set of predicate words that includes bits above the clamp. It does this with carry-provoking sources and both signs of immediate, so every clamp position meets both zeroing settings and both predicate polarities.

// File: rtl/pred_simd_addi.sv
module pred_simd_addi #(
  parameter int DW    = 64,
  parameter int IMM_W = 12,
  parameter int VL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        ew,
  input  logic [VL_W-1:0]   vl,
  input  logic [1:0]        subvl,
  input  logic [DW/8-1:0]   pred,
  input  logic              inv,
  input  logic              zero,
  input  logic [IMM_W-1:0]  imm,
  input  logic [DW-1:0]     src,
  output logic              out_valid,
  output logic [DW-1:0]     dst,
  output logic [DW/8-1:0]   wen
);
  localparam int NB = DW / 8;
  localparam int NH = DW / 16;
  localparam int NW = DW / 32;

  logic [DW-1:0]  imm_x;
  logic [DW-1:0]  nxt_d;
  logic [NB-1:0]  nxt_w;
  logic [NB-1:0]  epred;
  int             cnt;
  int             gsz;

  assign imm_x = {{(DW-IMM_W){imm[IMM_W-1]}}, imm};
  assign epred = pred ^ {NB{inv}};
  assign gsz   = int'(subvl) + 1;
  assign cnt   = int'(vl) * gsz;

  function automatic logic [1:0] lane_ctl(input int e, input int n, input int g,
                                          input logic [NB-1:0] p, input logic z);
    logic inr, act;
    inr = e < n;
    act = inr && p[e / g];
    return {act || (inr && z), act};
  endfunction

  always_comb begin
    logic [1:0] c;
    nxt_d = src;
    nxt_w = '0;
    case (ew)
      2'd1: begin
        for (int e = 0; e < NH; e++) begin
          c = lane_ctl(e, cnt, gsz, epred, zero);
          if (c[0])      nxt_d[e*16 +: 16] = src[e*16 +: 16] + imm_x[15:0];
          else if (c[1]) nxt_d[e*16 +: 16] = '0;
          nxt_w[e*2 +: 2] = {2{c[1]}};
        end
      end
      2'd2: begin
        for (int e = 0; e < NW; e++) begin
          c = lane_ctl(e, cnt, gsz, epred, zero);
          if (c[0])      nxt_d[e*32 +: 32] = src[e*32 +: 32] + imm_x[31:0];
          else if (c[1]) nxt_d[e*32 +: 32] = '0;
          nxt_w[e*4 +: 4] = {4{c[1]}};
        end
      end
      default: begin
        for (int e = 0; e < NB; e++) begin
          c = lane_ctl(e, cnt, gsz, epred, zero);
          if (c[0])      nxt_d[e*8 +: 8] = src[e*8 +: 8] + imm_x[7:0];
          else if (c[1]) nxt_d[e*8 +: 8] = '0;
          nxt_w[e] = c[1];
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dst       <= '0;
      wen       <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        dst <= nxt_d;
        wen <= nxt_w;
      end
    end
  end

  logic [DW-1:0] wen_bits;
  always_comb
    for (int b = 0; b < NB; b++) wen_bits[b*8 +: 8] = {8{wen[b]}};

  a_r2_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_idle_next: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r4_vl0_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && vl == '0) |=> (wen == '0));
  a_r8_all_masked_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !zero && (pred ^ {NB{inv}}) == '0) |=> (wen == '0));
  a_r9_all_masked_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && zero && (pred ^ {NB{inv}}) == '0) |=> ((dst & wen_bits) == '0));
  a_r10_unwritten_kept: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (((dst ^ $past(src)) & ~wen_bits) == '0));
endmodule

// File: tb/pred_simd_addi_tb.sv
module pred_simd_addi_tb;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  ew = '0;
  logic [3:0]  vl = '0;
  logic [1:0]  subvl = '0;
  logic [7:0]  pred = '0;
  logic        inv = 1'b0;
  logic        zero = 1'b0;
  logic [11:0] imm = '0;
  logic [63:0] src = '0;
  logic        out_valid;
  logic [63:0] dst;
  logic [7:0]  wen;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  pred_simd_addi u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ew(ew), .vl(vl),
    .subvl(subvl), .pred(pred), .inv(inv), .zero(zero), .imm(imm),
    .src(src), .out_valid(out_valid), .dst(dst), .wen(wen));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic void model(output logic [63:0] d, output logic [7:0] w);
    longint eb, ne, n, g, e, mask, elem, sum, sx;
    bit act, inr;
    eb = (ew == 2'd3) ? 1 : (1 << ew);
    ne = 8 / eb;
    g = longint'(subvl) + 1;
    n = longint'(vl) * g;
    if (n > ne) n = ne;
    mask = (eb == 4) ? 64'hFFFF_FFFF : ((64'd1 << (eb*8)) - 1);
    sx = longint'($signed(imm));
    d = src;
    w = '0;
    for (int b = 0; b < 8; b++) begin
      e = b / eb;
      inr = e < n;
      act = inr && (pred[e/g] ^ inv);
      elem = longint'((src >> (e*eb*8))) & mask;
      sum = (elem + sx) & mask;
      if (act) begin
        d[b*8 +: 8] = 8'(sum >> ((b % eb) * 8));
        w[b] = 1'b1;
      end else if (inr && zero) begin
        d[b*8 +: 8] = 8'h00;
        w[b] = 1'b1;
      end
    end
  endfunction

  task automatic apply_check;
    logic [63:0] ed;
    logic [7:0]  ewn;
    model(ed, ewn);
    in_valid = 1'b1;
    @(negedge clk);
    chk("R2 valid", {63'd0, out_valid}, 64'd1);
    chk("R3/R5/R6/R7/R8/R9 dst", dst, ed);
    chk("R4/R10 wen", {56'd0, wen}, {56'd0, ewn});
  endtask

  task automatic doc_case(input logic [7:0] p, input logic iv, input logic z,
                          input logic [31:0] e32);
    ew = 2'd0; vl = 4'd2; subvl = 2'd1; pred = p; inv = iv; zero = z;
    imm = 12'd1; src = 64'h0000_0000_4142_4344;
    in_valid = 1'b1;
    @(negedge clk);
    chk("R5/R6/R8/R9 directed", dst, {32'd0, e32});
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] srcs [3];
    logic [11:0] imms [3];
    logic [7:0]  preds [6];
    srcs[0] = 64'h0123_4567_89AB_CDEF;
    srcs[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    srcs[2] = 64'h80FF_7F00_FF80_017F;
    imms[0] = 12'd1; imms[1] = 12'hFFF; imms[2] = 12'h7A5;
    preds[0] = 8'h00; preds[1] = 8'h01; preds[2] = 8'h02;
    preds[3] = 8'h05; preds[4] = 8'hA6; preds[5] = 8'hFF;

    @(negedge clk);
    chk("R1 reset valid", {63'd0, out_valid}, 64'd0);
    chk("R1 reset dst", dst, 64'd0);
    chk("R1 reset wen", {56'd0, wen}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {out_valid, wen, dst[54:0]}, 64'd0);

    doc_case(8'h1, 0, 0, 32'h41424445);
    doc_case(8'h2, 0, 0, 32'h42434344);
    doc_case(8'h3, 0, 0, 32'h42434445);
    doc_case(8'h0, 0, 0, 32'h41424344);
    doc_case(8'h1, 0, 1, 32'h00004445);
    doc_case(8'h2, 0, 1, 32'h42430000);
    doc_case(8'h0, 0, 1, 32'h00000000);
    doc_case(8'h1, 1, 0, 32'h42434344);
    doc_case(8'h3, 1, 0, 32'h41424344);
    doc_case(8'h1, 1, 1, 32'h42430000);
    doc_case(8'h3, 1, 1, 32'h00000000);
    doc_case(8'h0, 1, 1, 32'h42434445);

    in_valid = 1'b0;
    @(negedge clk);
    chk("R2 idle drops valid", {63'd0, out_valid}, 64'd0);

    ew = 2'd0; vl = 4'd8; subvl = 2'd0; pred = 8'hFF; inv = 0; zero = 0;
    imm = 12'd1; src = 64'h00FF_00FF_00FF_00FF;
    in_valid = 1'b1;
    @(negedge clk);
    chk("R7 lane wrap no carry", dst, 64'h0100_0100_0100_0100);

    for (int w = 0; w < 4; w++)
      for (int s = 0; s < 4; s++)
        for (int v = 0; v < 6; v++)
          for (int p = 0; p < 6; p++)
            for (int k = 0; k < 3; k++)
              for (int m = 0; m < 4; m++) begin
                ew = 2'(w); subvl = 2'(s); vl = 4'(v); pred = preds[p];
                src = srcs[k]; imm = imms[(k + m) % 3];
                inv = m[0]; zero = m[1];
                apply_check();
              end

    in_valid = 1'b0;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule